// File: doc/BRIEF.md
# Two-Dimensional Parity Frame Encoder and Checker

This block protects short frames of 7-bit characters with two crossed layers of parity. In transmit direction it takes characters from a valid/ready byte stream, adds a parity bit to each one so that every coded byte has the chosen parity sense, and keeps a running modulo-2 sum of every bit column of the coded bytes. When the character flagged as last has been sent, it appends that column sum as one extra check byte, which closes the frame on the output stream.

In receive direction the same block takes coded bytes, the final one being the check byte. It tests each data byte's parity and reports a bad one on the following cycle. It rebuilds the column sum from the data bytes and compares it with the received check byte. One cycle after the check byte it gives a single pass or fail verdict. That verdict would drive a retransmission decision further up the stack.

The direction and the parity sense are static configuration inputs. They are changed only between frames while the block is idle.

Top module: `tdp_frame_check`

## Requirements
- R1: In transmit direction each output byte for a character carries the 7 data bits in bits 6:0 and the parity bit in bit 7. With even sense the byte holds an even count of ones, so data 1010010 gives 0xD2.
- R2: With odd sense the coded byte holds an odd count of ones, so 1010010 gives 0x52 and 1000111 gives 0xC7.
- R3: After the character marked last, exactly one further byte is emitted. It equals the bitwise XOR of all coded bytes of the frame, and out_last is high on it and on no other byte. The input accepts again once that byte has left.
- R4: In transmit direction, bit 7 of in_data has no effect on any output byte.
- R5: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold. Every byte is delivered once, in order, for any pattern of in_valid and out_ready.
- R6: The column sum starts from zero for every frame, both after a completed frame and after a synchronous reset taken in the middle of a frame. From acceptance of the last character until its check byte leaves, in_ready is low.
- R7: In receive direction, char_err pulses for one cycle, on the cycle after a data byte with the wrong parity for the selected sense is accepted. It is never raised for the check byte.
- R8: In receive direction, on the cycle after the check byte is accepted, exactly one of frame_good and frame_bad pulses for one cycle. frame_good is given only when every data byte had correct parity and the XOR of the data bytes equals the check byte.
- R9: In receive direction, in_ready is always high and out_valid stays low.
- R10: During and right after reset, out_valid, char_err, frame_good and frame_bad are low, and in_ready is high in transmit direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_rx | input | 1 | Direction: 0 encode and append, 1 verify |
| cfg_odd | input | 1 | Parity sense: 0 even, 1 odd |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Character in bits 6:0 (transmit) or full coded byte (receive) |
| in_last | input | 1 | Marks the last character (transmit) or the check byte (receive) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Coded byte or check byte |
| out_last | output | 1 | High on the appended check byte |
| char_err | output | 1 | Per-character parity error pulse (receive) |
| frame_good | output | 1 | Frame verdict pass pulse (receive) |
| frame_bad | output | 1 | Frame verdict fail pulse (receive) |

## Verification
A column sum that is not cleared or is updated on the wrong handshake stays hidden until the end of a frame. It then shows as a wrong check byte in transmit or a wrong verdict in receive, so frames of one to eight characters are sent back to back, and a reset is forced mid-frame, to make stale state surface within the next frame. A lost or stuck pending-check flag shows within one or two cycles as a missing or repeated last byte, or as an input accepted before the check byte leaves. Random output stalls expose any byte that changes while held. A sticky parity-error memory would turn the following clean frame bad, so corrupted and clean frames are interleaved.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
   typedef enum logic {SENSE_EVEN = 1'b0, SENSE_ODD = 1'b1} sense_e;
   typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;
endpackage

// File: rtl/tdp_char_coder.sv
module tdp_char_coder
   import tdp_pkg::*;
#(
   parameter int DATA_W  = 7,
   parameter bit PAR_MSB = 1'b1,
   localparam int CODE_W = DATA_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   input  sense_e            sense_i,
   input  logic [CODE_W-1:0] rx_code_i,
   output logic [CODE_W-1:0] code_o,
   output logic              rx_bad_o
);
   logic par_bit;

   // parity bit completes the count of ones to the chosen sense
   assign par_bit = (^data_i) ^ sense_i;

   generate
      if (PAR_MSB) begin : g_par_high
         assign code_o = {par_bit, data_i};
      end else begin : g_par_low
         assign code_o = {data_i, par_bit};
      end
   endgenerate

   // a received word is wrong when its total parity differs from the sense
   assign rx_bad_o = (^rx_code_i) ^ sense_i;
endmodule

// File: rtl/tdp_col_acc.sv
module tdp_col_acc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr_i,
   input  logic         en_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] acc_o
);
   logic [W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         acc_q <= '0;
      end else if (en_i) begin
         acc_q <= acc_q ^ din_i;
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/tdp_tx_stage.sv
module tdp_tx_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] code_i,
   input  logic         last_i,
   input  logic [W-1:0] chk_i,
   input  logic         ready_i,
   output logic         take_o,
   output logic         chk_load_o,
   output logic         valid_o,
   output logic [W-1:0] data_o,
   output logic         last_o
);
   logic         vld_q;
   logic         pend_q;
   logic         last_q;
   logic [W-1:0] data_q;
   logic         free;

   assign free       = !vld_q || ready_i;
   assign take_o     = free && !pend_q;
   assign chk_load_o = pend_q && free;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q  <= 1'b0;
         pend_q <= 1'b0;
         last_q <= 1'b0;
         data_q <= '0;
      end else if (chk_load_o) begin
         vld_q  <= 1'b1;
         data_q <= chk_i;
         last_q <= 1'b1;
         pend_q <= 1'b0;
      end else if (load_i) begin
         vld_q  <= 1'b1;
         data_q <= code_i;
         last_q <= 1'b0;
         pend_q <= last_i;
      end else if (ready_i) begin
         vld_q  <= 1'b0;
      end
   end

   assign valid_o = vld_q;
   assign data_o  = data_q;
   assign last_o  = last_q;
endmodule

// File: rtl/tdp_rx_verdict.sv
module tdp_rx_verdict (
   input  logic clk,
   input  logic rst,
   input  logic fire_i,
   input  logic last_i,
   input  logic par_bad_i,
   input  logic col_match_i,
   output logic char_err_o,
   output logic good_o,
   output logic bad_o
);
   logic err_seen_q;
   logic err_q;
   logic good_q;
   logic bad_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         err_seen_q <= 1'b0;
         err_q      <= 1'b0;
         good_q     <= 1'b0;
         bad_q      <= 1'b0;
      end else begin
         err_q  <= 1'b0;
         good_q <= 1'b0;
         bad_q  <= 1'b0;
         if (fire_i && !last_i) begin
            err_q      <= par_bad_i;
            err_seen_q <= err_seen_q || par_bad_i;
         end else if (fire_i && last_i) begin
            good_q     <= col_match_i && !err_seen_q;
            bad_q      <= !(col_match_i && !err_seen_q);
            err_seen_q <= 1'b0;
         end
      end
   end

   assign char_err_o = err_q;
   assign good_o     = good_q;
   assign bad_o      = bad_q;
endmodule

// File: rtl/tdp_frame_check.sv
module tdp_frame_check
   import tdp_pkg::*;
#(
   parameter int DATA_W  = 7,
   parameter bit PAR_MSB = 1'b1,
   localparam int CODE_W = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_rx,
   input  logic              cfg_odd,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CODE_W-1:0] in_data,
   input  logic              in_last,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [CODE_W-1:0] out_data,
   output logic              out_last,
   output logic              char_err,
   output logic              frame_good,
   output logic              frame_bad
);
   generate
      if (DATA_W < 1 || DATA_W > 31) begin : g_bad_width
         initial $fatal(1, "tdp_frame_check: DATA_W out of range 1..31");
      end
   endgenerate

   dir_e              dir;
   sense_e            sense;
   logic [CODE_W-1:0] code;
   logic              par_bad;
   logic [CODE_W-1:0] acc;
   logic [CODE_W-1:0] acc_din;
   logic              acc_en;
   logic              acc_clr;
   logic              tx_take;
   logic              chk_load;
   logic              fire;
   logic              tx_load;
   logic              rx_fire;

   assign dir     = dir_e'(cfg_rx);
   assign sense   = sense_e'(cfg_odd);
   assign in_ready = (dir == DIR_RX) ? 1'b1 : tx_take;
   assign fire    = in_valid && in_ready;
   assign tx_load = fire && (dir == DIR_TX);
   assign rx_fire = fire && (dir == DIR_RX);

   assign acc_en  = tx_load || (rx_fire && !in_last);
   assign acc_din = tx_load ? code : in_data;
   assign acc_clr = chk_load || (rx_fire && in_last);

   tdp_char_coder #(
      .DATA_W (DATA_W),
      .PAR_MSB(PAR_MSB)
   ) i_coder (
      .data_i   (in_data[DATA_W-1:0]),
      .sense_i  (sense),
      .rx_code_i(in_data),
      .code_o   (code),
      .rx_bad_o (par_bad)
   );

   tdp_col_acc #(
      .W(CODE_W)
   ) i_acc (
      .clk  (clk),
      .rst  (rst),
      .clr_i(acc_clr),
      .en_i (acc_en),
      .din_i(acc_din),
      .acc_o(acc)
   );

   tdp_tx_stage #(
      .W(CODE_W)
   ) i_tx (
      .clk       (clk),
      .rst       (rst),
      .load_i    (tx_load),
      .code_i    (code),
      .last_i    (in_last),
      .chk_i     (acc),
      .ready_i   (out_ready),
      .take_o    (tx_take),
      .chk_load_o(chk_load),
      .valid_o   (out_valid),
      .data_o    (out_data),
      .last_o    (out_last)
   );

   tdp_rx_verdict i_rx (
      .clk        (clk),
      .rst        (rst),
      .fire_i     (rx_fire),
      .last_i     (in_last),
      .par_bad_i  (par_bad),
      .col_match_i(acc == in_data),
      .char_err_o (char_err),
      .good_o     (frame_good),
      .bad_o      (frame_bad)
   );
endmodule

// File: rtl/tdp_frame_check_sva.sv
module tdp_frame_check_sva #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_rx,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_last,
   input logic              out_valid,
   input logic              out_ready,
   input logic [CODE_W-1:0] out_data,
   input logic              out_last,
   input logic              char_err,
   input logic              frame_good,
   input logic              frame_bad
);
   a_r5_hold_stalled: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   a_r6_block_after_last: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && in_last && !cfg_rx |=> !in_ready);

   a_r3_reopen_after_check: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && out_last && !cfg_rx |=> in_ready);

   a_r7_err_follows_data: assert property (@(posedge clk) disable iff (rst)
      char_err |-> $past(in_valid && in_ready && !in_last && cfg_rx));

   a_r8_one_verdict: assert property (@(posedge clk) disable iff (rst)
      !(frame_good && frame_bad));

   a_r8_verdict_follows_check: assert property (@(posedge clk) disable iff (rst)
      frame_good || frame_bad |-> $past(in_valid && in_ready && in_last && cfg_rx));
endmodule

bind tdp_frame_check tdp_frame_check_sva #(.CODE_W(CODE_W)) i_sva (
   .clk       (clk),
   .rst       (rst),
   .cfg_rx    (cfg_rx),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last),
   .char_err  (char_err),
   .frame_good(frame_good),
   .frame_bad (frame_bad)
);

// File: tb/test_tdp_frame_check.sv
`timescale 1ns/1ps
module test_tdp_frame_check;
   logic       clk = 1'b0;
   logic       rst;
   logic       cfg_rx, cfg_odd;
   logic       in_valid, in_ready, in_last;
   logic [7:0] in_data;
   logic       out_valid, out_ready, out_last;
   logic [7:0] out_data;
   logic       char_err, frame_good, frame_bad;

   int n_chk = 0;
   int n_fail = 0;
   int hold_bad = 0;
   logic [7:0] first_out;

   always #2.5 clk = ~clk;

   tdp_frame_check i_tdp_frame_check (
      .clk(clk), .rst(rst), .cfg_rx(cfg_rx), .cfg_odd(cfg_odd),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
      .char_err(char_err), .frame_good(frame_good), .frame_bad(frame_bad)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] enc(input logic [6:0] d);
      return {(1'($countones(d)) ^ cfg_odd), d};
   endfunction

   function automatic bit par_ok(input logic [7:0] c);
      return 1'($countones(c)) == cfg_odd;
   endfunction

   task automatic tx_frame(input logic [6:0] d[$], input int vp, input int rp, input bit junk);
      logic [7:0] exp_q[$];
      logic [8:0] got[$];
      logic [7:0] col = 8'h00;
      logic [7:0] pd = 8'h00;
      bit pl = 1'b0;
      bit stall = 1'b0;
      int n = d.size();
      int i = 0;
      int cyc = 0;
      foreach (d[k]) begin
         exp_q.push_back(enc(d[k]));
         col ^= enc(d[k]);
      end
      exp_q.push_back(col);
      while (got.size() < n + 1 && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (stall && !(out_valid && out_data == pd && out_last == pl)) hold_bad++;
         out_ready = ($urandom % 100) < rp;
         if (i < n && ($urandom % 100) < vp) begin
            in_valid = 1'b1;
            in_data  = {junk ? 1'($urandom) : 1'b0, d[i]};
            in_last  = (i == n - 1);
         end else begin
            in_valid = 1'b0;
            in_last  = 1'b0;
         end
         #1;
         if (in_valid && in_ready) i++;
         if (out_valid && out_ready) got.push_back({out_last, out_data});
         stall = out_valid && !out_ready;
         pd = out_data;
         pl = out_last;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      chk(got.size() == n + 1, "R5 byte count", got.size(), n + 1);
      for (int k = 0; k < got.size() && k <= n; k++) begin
         if (k == n) chk(got[k] == {1'b1, exp_q[k]}, "R3 check byte", got[k], {1'b1, exp_q[k]});
         else chk(got[k] == {1'b0, exp_q[k]}, "R1 R4 coded byte", got[k], {1'b0, exp_q[k]});
      end
      first_out = (got.size() > 0) ? got[0][7:0] : 8'hxx;
      out_ready = 1'b1;
      repeat (2) @(negedge clk);
      chk(!out_valid, "R5 no extra byte", out_valid, 0);
      chk(in_ready, "R3 input reopens", in_ready, 1);
   endtask

   task automatic rx_frame(input logic [7:0] c[$], input int vp);
      int n = c.size();
      int i = 0;
      int mism = 0;
      int cyc = 0;
      bit pe = 1'b0;
      bit rdy_ok = 1'b1;
      bit good = 1'b1;
      bit fg, fb;
      logic [7:0] acc = 8'h00;
      for (int k = 0; k < n - 1; k++) begin
         acc ^= c[k];
         if (!par_ok(c[k])) good = 1'b0;
      end
      if (acc != c[n-1]) good = 1'b0;
      while (i < n && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (char_err != pe) mism++;
         if (frame_good || frame_bad) mism++;
         if (!in_ready || out_valid) rdy_ok = 1'b0;
         pe = 1'b0;
         if (($urandom % 100) < vp) begin
            in_valid = 1'b1;
            in_data  = c[i];
            in_last  = (i == n - 1);
         end else begin
            in_valid = 1'b0;
            in_last  = 1'b0;
         end
         #1;
         if (in_valid && in_ready) begin
            pe = (i < n - 1) && !par_ok(c[i]);
            i++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      fg = frame_good;
      fb = frame_bad;
      if (char_err) mism++;
      chk(mism == 0, "R7 parity error pulses", mism, 0);
      chk(fg == good && fb == !good, "R8 verdict", {fg, fb}, {good, !good});
      chk(rdy_ok, "R9 rx ready and no output", rdy_ok, 1);
      @(negedge clk);
      chk(!frame_good && !frame_bad, "R8 single-cycle verdict", {frame_good, frame_bad}, 0);
   endtask

   initial begin
      #900000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [6:0] dq[$];
      logic [7:0] cq[$];
      void'($urandom(32'd20240611));
      rst = 1'b1; cfg_rx = 1'b0; cfg_odd = 1'b0;
      in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk(!out_valid && !char_err && !frame_good && !frame_bad, "R10 reset outputs",
          {out_valid, char_err, frame_good, frame_bad}, 0);
      chk(in_ready, "R10 reset ready", in_ready, 1);
      rst = 1'b0;

      // directed parity values
      dq = {7'b1010010};
      tx_frame(dq, 100, 100, 1'b0);
      chk(first_out == 8'hD2, "R1 even 1010010", first_out, 8'hD2);
      cfg_odd = 1'b1;
      tx_frame(dq, 100, 100, 1'b0);
      chk(first_out == 8'h52, "R2 odd 1010010", first_out, 8'h52);
      dq = {7'b1000111};
      tx_frame(dq, 100, 100, 1'b0);
      chk(first_out == 8'hC7, "R2 odd 1000111", first_out, 8'hC7);

      // R4 junk upper bit and R5 heavy backpressure
      dq = {7'h7F, 7'h00, 7'h55, 7'h2A};
      tx_frame(dq, 100, 20, 1'b1);

      // R6 reset mid-frame, then a clean frame must not see the stale sum
      cfg_odd = 1'b0;
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h3C; in_last = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!out_valid, "R6 reset drops partial frame", out_valid, 0);
      dq = {7'h11, 7'h22};
      tx_frame(dq, 100, 100, 1'b0);

      // random transmit frames
      for (int f = 0; f < 40; f++) begin
         int n = 1 + ($urandom % 8);
         dq.delete();
         for (int k = 0; k < n; k++) dq.push_back(7'($urandom));
         cfg_odd = 1'($urandom);
         tx_frame(dq, 30 + ($urandom % 71), 30 + ($urandom % 71), 1'($urandom));
      end
      chk(hold_bad == 0, "R5 output held while stalled", hold_bad, 0);

      // receive direction
      cfg_rx = 1'b1;
      for (int f = 0; f < 50; f++) begin
         int nd = 1 + ($urandom % 6);
         int kind = $urandom % 5;
         logic [7:0] col = 8'h00;
         int a, b, x, y;
         cfg_odd = 1'($urandom);
         cq.delete();
         for (int k = 0; k < nd; k++) begin
            cq.push_back(enc(7'($urandom)));
            col ^= cq[k];
         end
         cq.push_back(col);
         a = $urandom % nd;
         b = (a + 1) % nd;
         x = $urandom % 8;
         y = (x + 1 + ($urandom % 7)) % 8;
         case (kind)
            1: cq[a][x] = ~cq[a][x];
            2: begin cq[a][x] = ~cq[a][x]; cq[a][y] = ~cq[a][y]; end
            3: cq[nd][x] = ~cq[nd][x];
            4: if (nd >= 2) begin
                  cq[a][x] = ~cq[a][x]; cq[a][y] = ~cq[a][y];
                  cq[b][x] = ~cq[b][x]; cq[b][y] = ~cq[b][y];
               end
            default: ;
         endcase
         rx_frame(cq, 40 + ($urandom % 61));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule